// File: doc/BRIEF.md
# Two-Wire Serial Configuration Memory with One-Time Lower-Half Lock

This block is the slave end of an I2C-compatible two-wire link in front of a 256-byte byte-addressed store. A host uses it to read fixed configuration data from a plug-in module, such as its size and timing. The block oversamples the clock and data lines with its own system clock and finds START and STOP conditions. It answers a device byte whose type code and three strap bits match. It keeps an auto-incrementing word pointer, so the host can do byte writes, page writes, random reads, current-address reads and sequential reads. The data line is open-drain: the block only ever pulls it low.

Written bytes first collect in a one-page staging buffer. On STOP they are moved into the store in a single step, and a self-timed busy period follows. Its length is the parameter `WRITE_CYCLES`, so a simulation can use a short value. While busy, the block ignores its own address. A host can therefore poll the address until it is acknowledged.

A second type code reaches a lock latch. Any acknowledged write transaction to that code sets the latch when the transaction's STOP arrives. From then on, writes to the lower half of the store are acknowledged but thrown away. Only the block reset clears the latch. That reset also returns every byte of the store to 0xFF.

Top module: `serial_config_mem`

## Requirements
- R1: After reset, `sda_drive_low_o` is 0, every byte of the store reads 0xFF and the lock is clear.
- R2: The device byte is the first byte after a START. It is acknowledged only when all of the following hold: its bits 7:4 are 1010 (store access) or 0110 (lock access, write only), its bits 3:1 equal `dev_sel_i`, and the block is not busy. Bit 0 = 1 means read. Any other device byte, including a read aimed at 0110, gets no acknowledge, and the block stays silent until the next START.
- R3: A store write is: device byte with bit 0 = 0, then the word-address byte, then data bytes, each acknowledged. The bytes are held until STOP and are then written into the store. A random read is a write that carries only the word address, followed by a repeated START and a read device byte. It returns the byte at that address.
- R4: Each byte sent to the host advances the word pointer by one, and the pointer wraps from 0xFF to 0x00. A read that is not preceded by a word address (a current-address read) starts at the pointer left by the previous access.
- R5: One write transaction holds up to 16 data bytes. The low 4 address bits advance and wrap within the 16-byte page, and the upper 4 bits stay fixed. Bytes beyond the 16th overwrite earlier bytes of the same page.
- R6: A STOP that ends a write carrying at least one data byte, or a lock access, starts a busy period of `WRITE_CYCLES` clocks. During it, device bytes of both type codes get no acknowledge.
- R7: Once the lock is set, data bytes aimed at addresses 0x00–0x7F are still acknowledged but leave the store unchanged. Addresses 0x80–0xFF are still written normally.
- R8: No transaction clears the lock. Only `rst_n` clears it.
- R9: After a byte sent to the host, a NACK from the host (data line high) makes the block release the data line. The block does not drive it again until a new START.
- R10: `sda_drive_low_o` changes only while the sampled clock line is low, except when a START or STOP releases it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset; also clears the store and the lock |
| dev_sel_i | input | 3 | Strap value compared with device byte bits 3:1 |
| scl_i | input | 1 | Two-wire clock line as seen on the bus |
| sda_i | input | 1 | Two-wire data line as seen on the bus |
| sda_drive_low_o | output | 1 | 1 pulls the data line low (open-drain driver enable) |

## Verification
Device bytes are varied in strap bits, in type code and in direction bit. This separates a true address match from a match on the type code alone, and shows that a read aimed at the lock code is refused. Page writes start in the middle of a page and run past 16 bytes, which shows whether the pointer wraps within the page or carries into the next one. Sequential reads that cross 0xFF, followed by a current-address read, show whether the pointer wraps and whether it is kept between transactions. Writes just below and just above 0x80, each before and after the lock, and a lock attempt repeated before and after a reset, show that the lock covers only the lower half and stays set.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;
   timeunit 1ns;
   timeprecision 100ps;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_WORD,
      ST_WORD_ACK,
      ST_RX,
      ST_RX_ACK,
      ST_TX,
      ST_MACK
   } link_state_e;
endpackage

// File: rtl/cfgmem_line_sampler.sv
module cfgmem_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   timeunit 1ns;
   timeprecision 100ps;

   logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sync <= '1;
         sda_sync <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
         sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
         scl_q    <= scl_lvl;
         sda_q    <= sda_lvl;
      end
   end

   assign scl_lvl   = scl_sync[SYNC_STAGES-1];
   assign sda_lvl   = sda_sync[SYNC_STAGES-1];
   assign scl_rise  = scl_lvl & ~scl_q;
   assign scl_fall  = ~scl_lvl & scl_q;
   assign start_det = scl_lvl & scl_q & sda_q & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/cfgmem_store.sv
module cfgmem_store #(
   parameter int MEM_BYTES    = 256,
   parameter int PAGE_BYTES   = 16,
   parameter int PROT_BYTES   = 128,
   parameter int WRITE_CYCLES = 1_200_000,
   localparam int AW = $clog2(MEM_BYTES),
   localparam int PW = $clog2(PAGE_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stage_en,
   input  logic [PW-1:0] stage_idx,
   input  logic [AW-PW-1:0] stage_base,
   input  logic [7:0]    stage_data,
   input  logic          stage_clr,
   input  logic          lock_req,
   input  logic          commit,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data,
   output logic          busy,
   output logic          lock_set
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int CW = $clog2(WRITE_CYCLES + 1);
   localparam logic [AW:0] PROT_LIM = (AW+1)'(PROT_BYTES);

   logic [7:0]            mem_q  [MEM_BYTES];
   logic [7:0]            page_q [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] vld_q;
   logic [AW-PW-1:0]      base_q;
   logic                  lock_q, lock_pend_q;
   logic [CW-1:0]         busy_cnt;
   logic [AW-1:0]         slot_addr [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] slot_ok;

   // one target address and one permission per staging slot
   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
      assign slot_addr[g] = {base_q, PW'(g)};
      assign slot_ok[g]   = vld_q[g] & ~(lock_q & ({1'b0, slot_addr[g]} < PROT_LIM));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < MEM_BYTES; i++) mem_q[i] <= 8'hFF;
         for (int i = 0; i < PAGE_BYTES; i++) page_q[i] <= 8'h00;
         vld_q       <= '0;
         base_q      <= '0;
         lock_q      <= 1'b0;
         lock_pend_q <= 1'b0;
         busy_cnt    <= '0;
      end else begin
         if (busy_cnt != '0) busy_cnt <= busy_cnt - CW'(1);
         if (stage_clr) begin
            vld_q       <= '0;
            lock_pend_q <= 1'b0;
         end else if (commit) begin
            if ((|vld_q) || lock_pend_q) busy_cnt <= CW'(WRITE_CYCLES);
            for (int i = 0; i < PAGE_BYTES; i++)
               if (slot_ok[i]) mem_q[slot_addr[i]] <= page_q[i];
            lock_q      <= lock_q | lock_pend_q;
            vld_q       <= '0;
            lock_pend_q <= 1'b0;
         end else begin
            if (stage_en) begin
               page_q[stage_idx] <= stage_data;
               vld_q[stage_idx]  <= 1'b1;
               base_q            <= stage_base;
            end
            if (lock_req) lock_pend_q <= 1'b1;
         end
      end
   end

   assign rd_data  = mem_q[rd_addr];
   assign busy     = (busy_cnt != '0);
   assign lock_set = lock_q;
endmodule

// File: rtl/serial_config_mem.sv
module serial_config_mem
   import cfgmem_pkg::*;
#(
   parameter int MEM_BYTES    = 256,
   parameter int PAGE_BYTES   = 16,
   parameter int PROT_BYTES   = 128,
   parameter int WRITE_CYCLES = 1_200_000,
   parameter int SYNC_STAGES  = 2,
   parameter logic [3:0] ARRAY_TYPE = 4'b1010,
   parameter logic [3:0] LOCK_TYPE  = 4'b0110
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] dev_sel_i,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_drive_low_o
);
   timeunit 1ns;
   timeprecision 100ps;

   localparam int AW = $clog2(MEM_BYTES);
   localparam int PW = $clog2(PAGE_BYTES);

   // elaboration-time parameter checks
   if (MEM_BYTES != (1 << AW) || AW > 8)
      begin : g_bad_mem   $error("MEM_BYTES must be a power of two up to 256"); end
   if (PAGE_BYTES != (1 << PW) || PAGE_BYTES >= MEM_BYTES || PAGE_BYTES < 2)
      begin : g_bad_page  $error("PAGE_BYTES must be a power of two below MEM_BYTES"); end
   if (PROT_BYTES > MEM_BYTES || PROT_BYTES < 0)
      begin : g_bad_prot  $error("PROT_BYTES must not exceed MEM_BYTES"); end
   if (SYNC_STAGES < 2)
      begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   if (WRITE_CYCLES < 1 || ARRAY_TYPE == LOCK_TYPE)
      begin : g_bad_misc  $error("WRITE_CYCLES must be positive and type codes distinct"); end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic busy, lock_set;
   logic [7:0] rd_data;

   link_state_e   state;
   logic [3:0]    bit_cnt;
   logic [7:0]    shreg;
   logic [AW-1:0] ptr;
   logic          rd_dir, to_lock, mack, sda_oe_q;
   logic          byte_done, hit_array, hit_lock, stage_en, lock_req;

   cfgmem_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   assign byte_done = scl_fall && (bit_cnt == 4'd8);
   assign hit_array = (shreg[7:4] == ARRAY_TYPE) && (shreg[3:1] == dev_sel_i) && !busy;
   assign hit_lock  = (shreg[7:4] == LOCK_TYPE) && (shreg[3:1] == dev_sel_i) && !shreg[0] && !busy;
   assign stage_en  = (state == ST_RX) && byte_done && !to_lock;
   assign lock_req  = (state == ST_DEV) && byte_done && hit_lock;

   cfgmem_store #(
      .MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
      .PROT_BYTES(PROT_BYTES), .WRITE_CYCLES(WRITE_CYCLES)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .stage_en(stage_en), .stage_idx(ptr[PW-1:0]), .stage_base(ptr[AW-1:PW]),
      .stage_data(shreg), .stage_clr(start_det), .lock_req(lock_req), .commit(stop_det),
      .rd_addr(ptr), .rd_data(rd_data), .busy(busy), .lock_set(lock_set));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         ptr      <= '0;
         rd_dir   <= 1'b0;
         to_lock  <= 1'b0;
         mack     <= 1'b0;
         sda_oe_q <= 1'b0;
      end else if (start_det) begin
         state    <= ST_DEV;
         bit_cnt  <= '0;
         sda_oe_q <= 1'b0;
      end else if (stop_det) begin
         state    <= ST_IDLE;
         sda_oe_q <= 1'b0;
      end else begin
         case (state)
            ST_DEV, ST_WORD, ST_RX: begin
               if (scl_rise) begin
                  shreg   <= {shreg[6:0], sda_lvl};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_done) begin
                  if (state == ST_DEV) begin
                     if (hit_array || hit_lock) begin
                        sda_oe_q <= 1'b1;
                        state    <= ST_DEV_ACK;
                        to_lock  <= hit_lock;
                        rd_dir   <= shreg[0];
                     end else begin
                        state <= ST_IDLE;
                     end
                  end else if (state == ST_WORD) begin
                     ptr      <= shreg[AW-1:0];
                     sda_oe_q <= 1'b1;
                     state    <= ST_WORD_ACK;
                  end else begin
                     if (!to_lock) ptr <= {ptr[AW-1:PW], ptr[PW-1:0] + PW'(1)};
                     sda_oe_q <= 1'b1;
                     state    <= ST_RX_ACK;
                  end
               end
            end
            ST_DEV_ACK, ST_WORD_ACK, ST_RX_ACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  if (state == ST_DEV_ACK && rd_dir) begin
                     shreg    <= rd_data;
                     ptr      <= ptr + AW'(1);
                     sda_oe_q <= ~rd_data[7];
                     state    <= ST_TX;
                  end else begin
                     sda_oe_q <= 1'b0;
                     state    <= (state == ST_DEV_ACK && !to_lock) ? ST_WORD : ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     sda_oe_q <= 1'b0;
                     state    <= ST_MACK;
                  end else begin
                     shreg    <= {shreg[6:0], 1'b0};
                     sda_oe_q <= ~shreg[6];
                     bit_cnt  <= bit_cnt + 4'd1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  mack <= ~sda_lvl;
               end else if (scl_fall) begin
                  bit_cnt <= '0;
                  if (mack) begin
                     shreg    <= rd_data;
                     ptr      <= ptr + AW'(1);
                     sda_oe_q <= ~rd_data[7];
                     state    <= ST_TX;
                  end else begin
                     state <= ST_IDLE;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign sda_drive_low_o = sda_oe_q;
endmodule

// File: rtl/cfgmem_checker.sv
module cfgmem_checker
   import cfgmem_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        scl_lvl,
   input logic        start_det,
   input logic        stop_det,
   input logic        sda_oe,
   input logic        busy,
   input logic        lock_set,
   input link_state_e state
);
   timeunit 1ns;
   timeprecision 100ps;

   assert_drive_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

   assert_no_ack_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV_ACK && $past(state) != ST_DEV_ACK) |-> !$past(busy));

   assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock_set) |-> lock_set);

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   assert_ack_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEV_ACK) |-> sda_oe);
endmodule

bind serial_config_mem cfgmem_checker u_chk (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .start_det(start_det),
   .stop_det(stop_det), .sda_oe(sda_oe_q), .busy(busy), .lock_set(lock_set),
   .state(state));

// File: tb/tb_serial_config_mem.sv
module tb_serial_config_mem;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int         WCYC  = 1000;
   localparam logic [2:0] STRAP = 3'b101;
   localparam logic [3:0] T_ARR = 4'b1010;
   localparam logic [3:0] T_LCK = 4'b0110;
   localparam time        Q     = 50;

   logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1;
   logic sda_drive_low, sda_bus;
   assign sda_bus = sda_m & ~sda_drive_low;

   always #2.5 clk = ~clk;

   serial_config_mem #(.WRITE_CYCLES(WCYC)) dut (
      .clk(clk), .rst_n(rst_n), .dev_sel_i(STRAP), .scl_i(scl), .sda_i(sda_bus),
      .sda_drive_low_o(sda_drive_low));

   int checks = 0, failures = 0;
   logic [7:0] model [256];
   bit         wp_model;
   logic [7:0] ptr_model;
   logic [7:0] wbuf [32];
   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic [7:0] obs_byte;
   event       obs_ev;

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         @(obs_ev);
         if (exp_q.size() == 0) begin
            check("R3 scoreboard unexpected byte", obs_byte, 256);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, obs_byte, e);
         end
      end
   end

   // R10: driver changes only while clock is low
   always @(sda_drive_low) if (rst_n) check("R10 data drive changed with clock high", scl, 0);

   function automatic logic [7:0] devb(input logic [3:0] t, input logic [2:0] s, input bit rd);
      return {t, s, rd};
   endfunction

   task automatic send_bit(input bit b);
      sda_m = b; #Q; scl = 1'b1; #(2*Q); scl = 1'b0; #Q;
   endtask

   task automatic recv_bit(output bit b);
      sda_m = 1'b1; #Q; scl = 1'b1; #Q; b = sda_bus; #Q; scl = 1'b0; #Q;
   endtask

   task automatic bus_start;
      sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q; scl = 1'b0; #Q;
   endtask

   task automatic bus_stop;
      sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #Q;
   endtask

   task automatic put_byte(input logic [7:0] b, output bit ack);
      bit r;
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      recv_bit(r);
      ack = !r;
   endtask

   task automatic get_byte(input bit give_ack, output logic [7:0] v);
      bit r;
      for (int i = 7; i >= 0; i--) begin recv_bit(r); v[i] = r; end
      send_bit(!give_ack);
      obs_byte = v;
      -> obs_ev;
   endtask

   task automatic write_seq(input logic [7:0] addr, input int n, input string tag);
      bit ack;
      logic [3:0] idx;
      bus_start;
      put_byte(devb(T_ARR, STRAP, 1'b0), ack); check({tag, " device ack"}, ack, 1);
      put_byte(addr, ack);                     check({tag, " word ack"}, ack, 1);
      idx = addr[3:0];
      for (int i = 0; i < n; i++) begin
         put_byte(wbuf[i], ack);               check({tag, " data ack"}, ack, 1);
         if (!(wp_model && addr[7:4] < 4'h8)) model[{addr[7:4], idx}] = wbuf[i];
         idx = idx + 4'd1;
      end
      bus_stop;
      ptr_model = {addr[7:4], idx};
   endtask

   task automatic wait_ready(input string tag);
      bit ack = 0;
      for (int p = 0; p < 20 && !ack; p++) begin
         bus_start;
         put_byte(devb(T_ARR, STRAP, 1'b0), ack);
         bus_stop;
      end
      check({tag, " R6 ready after busy"}, ack, 1);
   endtask

   task automatic read_rand(input logic [7:0] addr, input int n, input string tag);
      bit ack;
      logic [7:0] v;
      bus_start;
      put_byte(devb(T_ARR, STRAP, 1'b0), ack); check({tag, " device ack"}, ack, 1);
      put_byte(addr, ack);                     check({tag, " word ack"}, ack, 1);
      bus_start;
      put_byte(devb(T_ARR, STRAP, 1'b1), ack); check({tag, " read ack"}, ack, 1);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(model[8'(addr + 8'(i))]);
         tag_q.push_back(tag);
         get_byte(i != n - 1, v);
      end
      bus_stop;
      ptr_model = 8'(addr + 8'(n));
   endtask

   task automatic read_cur(input int n, input string tag);
      bit ack;
      logic [7:0] v;
      bus_start;
      put_byte(devb(T_ARR, STRAP, 1'b1), ack); check({tag, " read ack"}, ack, 1);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(model[8'(ptr_model + 8'(i))]);
         tag_q.push_back(tag);
         get_byte(i != n - 1, v);
      end
      bus_stop;
      ptr_model = 8'(ptr_model + 8'(n));
   endtask

   task automatic expect_nack(input logic [7:0] d, input string tag);
      bit ack;
      bus_start;
      put_byte(d, ack);
      bus_stop;
      check(tag, ack, 0);
   endtask

   task automatic lock_access(input string tag);
      bit ack;
      bus_start;
      put_byte(devb(T_LCK, STRAP, 1'b0), ack); check({tag, " lock device ack"}, ack, 1);
      put_byte(8'h00, ack);                    check({tag, " lock byte ack"}, ack, 1);
      bus_stop;
      wp_model = 1'b1;
   endtask

   task automatic model_reset;
      for (int i = 0; i < 256; i++) model[i] = 8'hFF;
      wp_model  = 1'b0;
      ptr_model = 8'h00;
   endtask

   initial begin
      #(900_000);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      model_reset;
      #101;
      rst_n = 1'b1;
      #(2*Q);
      check("R1 data line released after reset", sda_drive_low, 0);
      read_rand(8'h10, 2, "R1 erased contents");

      // R2 address decode
      expect_nack(devb(T_ARR, 3'b100, 1'b0), "R2 wrong strap refused");
      expect_nack(devb(4'b1011, STRAP, 1'b0), "R2 wrong type refused");
      expect_nack(devb(T_LCK, STRAP, 1'b1), "R2 read of lock code refused");

      // R3 byte write, then R6 busy polling
      wbuf[0] = 8'hA5;
      write_seq(8'h10, 1, "R3 byte write");
      expect_nack(devb(T_ARR, STRAP, 1'b0), "R6 store address refused while busy");
      expect_nack(devb(T_LCK, STRAP, 1'b0), "R6 lock address refused while busy");
      wait_ready("R3");
      read_rand(8'h10, 1, "R3 random read");

      // R5 page write from mid page, 18 bytes wrap within page
      for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'h40 + 8'(i * 3));
      write_seq(8'h2E, 18, "R5 page write");
      wait_ready("R5");
      read_rand(8'h20, 16, "R5 page wrap contents");
      read_rand(8'h30, 1, "R5 next page untouched");

      // R4 pointer wrap and current-address read
      wbuf[0] = 8'h3C;
      write_seq(8'hFF, 1, "R4 top byte write");
      wait_ready("R4");
      read_rand(8'hFE, 3, "R4 sequential wrap");
      read_cur(2, "R4 current address");

      // R9 host NACK ends the read; further clocks see no drive
      begin
         bit ack, r;
         logic [7:0] v;
         logic [7:0] idle_bits;
         bus_start;
         put_byte(devb(T_ARR, STRAP, 1'b1), ack); check("R9 read ack", ack, 1);
         exp_q.push_back(model[ptr_model]);
         tag_q.push_back("R9 last byte");
         get_byte(1'b0, v);
         ptr_model = 8'(ptr_model + 8'd1);
         for (int i = 7; i >= 0; i--) begin recv_bit(r); idle_bits[i] = r; end
         recv_bit(r);
         check("R9 no drive after host NACK", idle_bits, 8'hFF);
         check("R9 no ack slot drive", r, 1);
         bus_stop;
      end

      // R7 lock covers only the lower half
      wbuf[0] = 8'h11;
      write_seq(8'h7F, 1, "R7 pre-lock write");
      wait_ready("R7");
      lock_access("R7");
      wait_ready("R7 lock");
      wbuf[0] = 8'h22;
      write_seq(8'h7F, 1, "R7 protected write acked");
      wait_ready("R7");
      wbuf[0] = 8'h33;
      write_seq(8'h80, 1, "R7 upper write");
      wait_ready("R7");
      read_rand(8'h7F, 2, "R7 lower kept upper written");

      // R8 lock persists across transactions; reset clears it
      lock_access("R8");
      wait_ready("R8");
      wbuf[0] = 8'h55; wbuf[1] = 8'h66;
      write_seq(8'h06, 2, "R8 still locked write");
      wait_ready("R8");
      read_rand(8'h05, 3, "R8 still locked contents");
      #Q;
      rst_n = 1'b0;
      #Q;
      rst_n = 1'b1;
      model_reset;
      #(2*Q);
      wbuf[0] = 8'h44;
      write_seq(8'h05, 1, "R8 write after reset");
      wait_ready("R8");
      read_rand(8'h04, 3, "R8 reset cleared lock and contents");

      #(4*Q);
      check("R3 scoreboard drained", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule